// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This core runs programs whose arithmetic names no operands. Values are put on an operand stack from data memory or from a constant in the instruction. Add and multiply take the two uppermost entries and leave their result in their place. A pop writes the uppermost entry back to a data memory address. Instructions are 24 bits wide and come from an instruction memory addressed by a program counter that starts at zero. The core runs until it meets a halt instruction or an error.

The four uppermost stack entries sit in registers. When a push finds all four in use, the core first copies the deepest register entry to a reserved area of data memory, one extra cycle per word. When an operation needs more register entries than are present, the core brings the most recently saved word back from that area, again one cycle per word. A single data memory port carries both the program's own loads and stores and this spill and fill traffic. Both memories are read combinationally, and data memory is written at the clock edge.

Top module: `stk_core`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0, `halted` and `error` are 0, and `dmem_we` is 0.
- R2: The opcode is `imem_data[23:16]` and the operand is `imem_data[15:0]`. The codes are 0x01 push-from-memory, 0x02 push-constant, 0x03 pop-to-memory, 0x04 add, 0x05 multiply and 0xFF halt. Any other code does nothing except advance the program counter by one. With no stall, every instruction takes one cycle.
- R3: Push-from-memory pushes `dmem[operand]` and push-constant pushes the operand itself. Pop-to-memory writes the uppermost entry to `dmem[operand]` and removes it. Entries come off in the reverse of the order in which they went on.
- R4: Add and multiply remove the two uppermost entries and push their sum, or the low 16 bits of their product, with no carry out.
- R5: The program push a, push-constant 145, push b, add, multiply, pop res leaves a*(145+b) mod 2^16 in res.
- R6: A push that finds 4 entries in registers first spends one cycle writing the deepest register entry to `dmem[SPILL_BASE+k]`, where k is the number of words already saved. The push then completes in the following cycle.
- R7: An instruction that needs more operands than the registers hold first spends one cycle per missing word reading `dmem[SPILL_BASE+k-1]` back into the deepest position. The instruction then completes.
- R8: An instruction that needs an operand when both the registers and the save area are empty sets `error` and `halted`. It does not write data memory or advance the program counter, and both flags stay set until reset.
- R9: A push that needs to save a word when the save area already holds SPILL_DEPTH words sets `error` and `halted`, with the program counter left on that push.
- R10: Halt sets `halted`. After that the program counter no longer changes and data memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program counter, the instruction memory address |
| imem_data | input | 24 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Data memory word address |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_rdata | input | 16 | Data memory read data at `dmem_addr` |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky stack underflow or save-area overflow |

## Verification
The case that needs care is when an instruction's own memory traffic meets spill or fill traffic on the one data port. This happens when a push arrives with the registers full, or when an add or a pop finds too few register entries while words are saved in memory. The bench provokes this by sweeping the number of pushed constants from one to eight, so that zero to four words go to the save area, and then draining them with chains of adds or pops. Each run is judged three ways: the final value or pop order in data memory, the saved words in the save area, and the exact cycle count of 2N+1+2s, where N is the number of pushes and s the number of saved words.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int OPC_W  = 8;
    localparam int ARG_W  = 16;
    localparam int DATA_W = 16;
    localparam int INSN_W = OPC_W + ARG_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [OPC_W-1:0] OPC_CONST = 8'h02;
    localparam logic [OPC_W-1:0] OPC_STORE = 8'h03;
    localparam logic [OPC_W-1:0] OPC_ADD   = 8'h04;
    localparam logic [OPC_W-1:0] OPC_MUL   = 8'h05;
    localparam logic [OPC_W-1:0] OPC_STOP  = 8'hFF;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [ARG_W-1:0] arg;
    } insn_t;

    typedef enum logic [2:0] {
        CA_NONE, CA_PUSH, CA_POP, CA_MERGE, CA_SPILL, CA_FILL
    } cache_op_e;

    typedef struct packed {
        logic [1:0] need;   // operands consumed from the stack
        logic       grows;  // adds one entry
    } opinfo_t;

    function automatic opinfo_t op_info(logic [OPC_W-1:0] opc);
        opinfo_t r;
        r = '{need: 2'd0, grows: 1'b0};
        case (opc)
            OPC_LOAD, OPC_CONST: r.grows = 1'b1;
            OPC_STORE:           r.need  = 2'd1;
            OPC_ADD, OPC_MUL:    r.need  = 2'd2;
            default:             r = '{need: 2'd0, grows: 1'b0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         use_mul,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = a * b;
        y    = use_mul ? prod[W-1:0] : a + b;
    end
endmodule

// File: rtl/stk_cache.sv
module stk_cache
    import stk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = DATA_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  cache_op_e      op,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   top,
    output logic [W-1:0]   second,
    output logic [W-1:0]   bottom,
    output logic [CW-1:0]  count
);
    // ent[0] is the stack top; ent[count-1] is the deepest cached entry
    logic [W-1:0]  ent [DEPTH];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (op)
                CA_PUSH: begin
                    ent[0] <= din;
                    for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
                    cnt_q <= cnt_q + 1'b1;
                end
                CA_POP: begin
                    for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
                    cnt_q <= cnt_q - 1'b1;
                end
                CA_MERGE: begin
                    ent[0] <= din;
                    for (int i = 1; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
                    cnt_q <= cnt_q - 1'b1;
                end
                CA_SPILL: cnt_q <= cnt_q - 1'b1;
                CA_FILL: begin
                    for (int i = 0; i < DEPTH; i++)
                        if (i == int'(cnt_q)) ent[i] <= din;
                    cnt_q <= cnt_q + 1'b1;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        top    = ent[0];
        second = ent[1];
        bottom = '0;
        for (int i = 0; i < DEPTH; i++)
            if (i + 1 == int'(cnt_q)) bottom = ent[i];
    end
    assign count = cnt_q;

    // R6: a spill only ever drains a full register stack
    a_r6_spill_when_full: assert property (@(posedge clk) disable iff (rst)
        op == CA_SPILL |-> cnt_q == CW'(DEPTH));
    // R7: a fill only lands when a register slot is free
    a_r7_fill_has_room: assert property (@(posedge clk) disable iff (rst)
        op == CA_FILL |-> cnt_q < CW'(DEPTH));
    // R4: arithmetic merge needs two cached operands
    a_r4_merge_two: assert property (@(posedge clk) disable iff (rst)
        op == CA_MERGE |-> cnt_q >= CW'(2));
    // R3: a pop never leaves the cache empty-underflowed
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        op == CA_POP |-> cnt_q != '0);
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int            PC_W        = 8,
    parameter int            CACHE_DEPTH = 4,
    parameter logic [15:0]   SPILL_BASE  = 16'h00C0,
    parameter int            SPILL_DEPTH = 64,
    localparam int           CW          = $clog2(CACHE_DEPTH + 1),
    localparam int           SW          = $clog2(SPILL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [23:0]       imem_data,
    output logic [15:0]       dmem_addr,
    output logic              dmem_we,
    output logic [15:0]       dmem_wdata,
    input  logic [15:0]       dmem_rdata,
    output logic              halted,
    output logic              error
);
    logic [PC_W-1:0] pc_q;
    logic            halt_q, err_q;
    logic [SW-1:0]   sdep_q;

    insn_t           ins;
    opinfo_t         info;
    cache_op_e       cop;
    logic [DATA_W-1:0] cdin, c_top, c_second, c_bottom, alu_y;
    logic [CW-1:0]   c_cnt;
    logic            adv, set_err, set_halt, do_spill, do_fill, run;

    stk_cache #(.DEPTH(CACHE_DEPTH), .W(DATA_W)) u_cache (
        .clk(clk), .rst(rst), .op(cop), .din(cdin),
        .top(c_top), .second(c_second), .bottom(c_bottom), .count(c_cnt)
    );

    stk_alu #(.W(DATA_W)) u_alu (
        .use_mul(ins.opc == OPC_MUL), .a(c_second), .b(c_top), .y(alu_y)
    );

    always_comb begin
        ins        = insn_t'(imem_data);
        info       = op_info(ins.opc);
        run        = !halt_q && !rst;
        cop        = CA_NONE;
        cdin       = '0;
        dmem_addr  = '0;
        dmem_we    = 1'b0;
        dmem_wdata = '0;
        adv        = 1'b0;
        set_err    = 1'b0;
        set_halt   = 1'b0;
        do_spill   = 1'b0;
        do_fill    = 1'b0;
        if (run) begin
            if (int'(c_cnt) < int'(info.need)) begin
                if (sdep_q != '0) begin
                    do_fill   = 1'b1;
                    dmem_addr = SPILL_BASE + 16'(sdep_q) - 16'd1;
                    cdin      = dmem_rdata;
                    cop       = CA_FILL;
                end else begin
                    set_err = 1'b1;
                end
            end else if (info.grows && c_cnt == CW'(CACHE_DEPTH)) begin
                if (sdep_q == SW'(SPILL_DEPTH)) begin
                    set_err = 1'b1;
                end else begin
                    do_spill   = 1'b1;
                    dmem_addr  = SPILL_BASE + 16'(sdep_q);
                    dmem_we    = 1'b1;
                    dmem_wdata = c_bottom;
                    cop        = CA_SPILL;
                end
            end else begin
                case (ins.opc)
                    OPC_LOAD: begin
                        dmem_addr = ins.arg;
                        cdin      = dmem_rdata;
                        cop       = CA_PUSH;
                        adv       = 1'b1;
                    end
                    OPC_CONST: begin
                        cdin = ins.arg;
                        cop  = CA_PUSH;
                        adv  = 1'b1;
                    end
                    OPC_STORE: begin
                        dmem_addr  = ins.arg;
                        dmem_we    = 1'b1;
                        dmem_wdata = c_top;
                        cop        = CA_POP;
                        adv        = 1'b1;
                    end
                    OPC_ADD, OPC_MUL: begin
                        cdin = alu_y;
                        cop  = CA_MERGE;
                        adv  = 1'b1;
                    end
                    OPC_STOP: set_halt = 1'b1;
                    default:  adv = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            halt_q <= 1'b0;
            err_q  <= 1'b0;
            sdep_q <= '0;
        end else begin
            if (adv) pc_q <= pc_q + 1'b1;
            if (do_spill) sdep_q <= sdep_q + 1'b1;
            else if (do_fill) sdep_q <= sdep_q - 1'b1;
            if (set_halt || set_err) halt_q <= 1'b1;
            if (set_err) err_q <= 1'b1;
        end
    end

    assign imem_addr = pc_q;
    assign halted    = halt_q;
    assign error     = err_q;

    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        error |=> error);
    // R8: an error always stops the core
    a_r8_err_halts: assert property (@(posedge clk) disable iff (rst)
        error |-> halted);
    // R10: stopped core holds its program counter
    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr) && halted);
    // R10: stopped core never writes data memory
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);
    // R1: no memory write while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> !dmem_we);
endmodule

// File: tb/stk_core_test.sv
module stk_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [23:0] imem_data;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted, error;

    logic [23:0] imem [0:63];
    logic [15:0] dmem [0:255];
    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] SB = 16'h00C0;

    always #5 clk = ~clk;

    stk_core #(.PC_W(8), .CACHE_DEPTH(4), .SPILL_BASE(SB), .SPILL_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .halted(halted), .error(error)
    );

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

    function automatic logic [23:0] ins(logic [7:0] opc, logic [15:0] arg);
        return {opc, arg};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 64; i++) imem[i] = 24'hFF0000;
        for (int i = 0; i < 256; i++) dmem[i] = 16'h0;
    endtask

    // reset, check R1 during reset, run until halted; returns edges taken
    task automatic run(output int cyc);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 0 && !halted && !error && !dmem_we, "R1",
            {imem_addr, halted, error, dmem_we}, 0);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) chk(1'b0, "watchdog", cyc, 500);
    endtask

    initial begin
        #1500000;
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cyc;
        int avals [5] = '{0, 1, 7, 300, 65535};
        int bvals [4] = '{0, 5, 1000, 65535};
        logic [15:0] v [9];

        // R5, R2: the reference expression over a grid of a and b
        foreach (avals[ia]) foreach (bvals[ib]) begin
            clear_all();
            dmem[8'h10] = 16'(avals[ia]);
            dmem[8'h11] = 16'(bvals[ib]);
            imem[0] = ins(8'h01, 16'h0010);
            imem[1] = ins(8'h02, 16'd145);
            imem[2] = ins(8'h01, 16'h0011);
            imem[3] = ins(8'h04, 16'h0);
            imem[4] = ins(8'h05, 16'h0);
            imem[5] = ins(8'h03, 16'h0012);
            run(cyc);
            chk(dmem[8'h12] == 16'(longint'(avals[ia]) * (145 + bvals[ib])), "R5",
                dmem[8'h12], 16'(longint'(avals[ia]) * (145 + bvals[ib])));
            chk(cyc == 7 && !error, "R2", cyc, 7);
        end

        // R6, R7, R4: N pushes then N-1 adds, spill and fill sweep
        for (int n = 1; n <= 8; n++) begin
            int s;
            logic [15:0] sum;
            clear_all();
            s = (n > 4) ? n - 4 : 0;
            sum = 16'h0;
            for (int k = 0; k < n; k++) begin
                v[k] = 16'(k * 9000 + 3);
                sum = sum + v[k];
                imem[k] = ins(8'h02, v[k]);
            end
            for (int k = 0; k < n - 1; k++) imem[n + k] = ins(8'h04, 16'h0);
            imem[2*n - 1] = ins(8'h03, 16'h0020);
            run(cyc);
            chk(dmem[8'h20] == sum, "R4", dmem[8'h20], sum);
            chk(cyc == 2*n + 1 + 2*s, "R7", cyc, 2*n + 1 + 2*s);
            for (int j = 0; j < s; j++)
                chk(dmem[SB[7:0] + 8'(j)] == v[j], "R6", dmem[SB[7:0] + 8'(j)], v[j]);
            chk(!error, "R6", error, 0);
        end

        // R3, R7: LIFO order through the save area
        clear_all();
        for (int k = 0; k < 7; k++) begin
            v[k] = 16'(k * 11 + 100);
            imem[k] = ins(8'h02, v[k]);
            imem[7 + k] = ins(8'h03, 16'(16'h0030 + k));
        end
        run(cyc);
        for (int k = 0; k < 7; k++)
            chk(dmem[8'h30 + 8'(k)] == v[6 - k], "R3", dmem[8'h30 + 8'(k)], v[6 - k]);
        chk(cyc == 21, "R7", cyc, 21);

        // R3: push from memory then pop elsewhere
        clear_all();
        dmem[8'h40] = 16'h1234;
        imem[0] = ins(8'h01, 16'h0040);
        imem[1] = ins(8'h03, 16'h0041);
        run(cyc);
        chk(dmem[8'h41] == 16'h1234, "R3", dmem[8'h41], 16'h1234);

        // R4: product truncation and sum wrap
        clear_all();
        imem[0] = ins(8'h02, 16'd300);
        imem[1] = ins(8'h02, 16'd300);
        imem[2] = ins(8'h05, 16'h0);
        imem[3] = ins(8'h03, 16'h0042);
        imem[4] = ins(8'h02, 16'hFFFF);
        imem[5] = ins(8'h02, 16'd2);
        imem[6] = ins(8'h04, 16'h0);
        imem[7] = ins(8'h03, 16'h0043);
        run(cyc);
        chk(dmem[8'h42] == 16'd24464, "R4", dmem[8'h42], 24464);
        chk(dmem[8'h43] == 16'd1, "R4", dmem[8'h43], 1);

        // R8: pop from empty stack
        clear_all();
        dmem[8'h50] = 16'hAAAA;
        imem[0] = ins(8'h03, 16'h0050);
        run(cyc);
        chk(error && halted && cyc == 1, "R8", {error, halted}, 3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(error && halted && imem_addr == 0, "R8", {error, imem_addr}, 9'h100);
        chk(dmem[8'h50] == 16'hAAAA, "R8", dmem[8'h50], 16'hAAAA);

        // R8: add with a single operand
        clear_all();
        imem[0] = ins(8'h02, 16'd9);
        imem[1] = ins(8'h04, 16'h0);
        run(cyc);
        chk(error && imem_addr == 1, "R8", imem_addr, 1);

        // R9: save area overflow on the ninth push
        clear_all();
        for (int k = 0; k < 9; k++) imem[k] = ins(8'h02, 16'(k + 1));
        run(cyc);
        chk(error && halted && imem_addr == 8, "R9", imem_addr, 8);

        // R2, R10: unknown opcode is skipped, halt freezes the core
        clear_all();
        imem[0] = ins(8'h02, 16'd5);
        imem[1] = ins(8'h33, 16'h0060);
        imem[2] = ins(8'h03, 16'h0060);
        run(cyc);
        chk(dmem[8'h60] == 16'd5 && cyc == 4, "R2", dmem[8'h60], 5);
        begin
            int writes = 0;
            for (int k = 0; k < 5; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (dmem_we) writes++;
            end
            chk(imem_addr == 3 && halted && !error, "R10", imem_addr, 3);
            chk(writes == 0, "R10", writes, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule